// File: doc/BRIEF.md
# Manchester Frame Receiver

This block takes a serial Manchester-coded line and turns framed bytes back into plain binary data. A programmable divider produces a sample tick, and sixteen ticks make one bit time. After it is enabled, the receiver waits until the line has been seen low for a full bit time. It then treats the next rising edge as the start of a two-bit sync field. Next come eight data bits, then a trailing bit and a two-bit pause. A byte is handed over only when every field of this frame is correct.

A good byte lands in a single holding register and raises a full flag. If the holding register has not been read when the next good byte arrives, that byte is dropped and an overrun flag is raised instead. The interrupt output is high while either flag is set. The consumer clears the flags with one-cycle strobes.

Top module: `mfd_rx`

## Requirements
- R1: Reset clears the holding register to 0x00 and drives full, overrun and irq low.
- R2: While en is low, the line is ignored and no byte is ever loaded. Raising en again restarts the receiver in its idle-confirm state.
- R3: A sample tick occurs every div+1 clock cycles. One bit time is 16 ticks, so the bit rate follows div.
- R4: Hunting for sync begins only after 16 consecutive low samples. A rising edge seen before that does not start a frame.
- R5: The sync field is two bit times with the line high, checked at ticks 4 and 12 of each bit counted from the starting rising edge. Any low sample in it discards the frame.
- R6: Data bits arrive least significant bit first. A bit whose first half is low and second half is high decodes as 1, and high then low decodes as 0.
- R7: A data bit period with the same level in both halves is a framing error. The frame is dropped and the receiver returns to the idle-confirm state, so a later correct frame is still received.
- R8: After the eighth data bit, the line must be high for one whole bit time (trailer) and then low for two bit times (pause). Any other level drops the byte.
- R9: A correct frame arriving while full is 0 writes the byte to data_out and sets full.
- R10: A correct frame arriving while full is 1 leaves data_out unchanged, keeps full at 1 and sets overrun.
- R11: A pulse on rd_stb clears full, and a pulse on ovr_clr clears overrun. An overrun set in the same cycle takes priority over ovr_clr.
- R12: irq is high exactly when full or overrun is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable; low holds the decoder off |
| div | input | DIV_W | Tick divider; tick period is div+1 clocks |
| line_in | input | 1 | Asynchronous Manchester line, idle low |
| rd_stb | input | 1 | One-cycle read strobe, clears full |
| ovr_clr | input | 1 | One-cycle strobe, clears overrun |
| data_out | output | NBITS | Holding register |
| full | output | 1 | Holding register holds an unread byte |
| overrun | output | 1 | A good byte was lost to an unread register |
| irq | output | 1 | Interrupt request, full or overrun |

## Verification
The assertions assume that rd_stb and ovr_clr are single-cycle strobes from the consumer. They also assume that div changes only while the line is idle between frames. The stimulus follows both rules. The bench changes div only after a frame has ended and the line has returned low. It holds each half-bit level for exactly eight tick periods, so the quarter-point and three-quarter-point samples fall well inside a stable half, even after the two-flop synchronizer and tick phase jitter.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

    localparam int OSR        = 16;
    localparam int PH_A       = 4;
    localparam int PH_B       = 12;
    localparam int SYNC_BITS  = 2;
    localparam int PAUSE_BITS = 2;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_START,
        ST_HUNT,
        ST_SYNC,
        ST_DATA,
        ST_TRAIL,
        ST_PAUSE
    } rx_state_e;

    typedef struct packed {
        logic a;   // first-half sample
        logic b;   // second-half sample
    } halves_t;

    // Is the pair of half-bit samples legal for the given field?
    function automatic logic halves_ok(rx_state_e st, halves_t h);
        case (st)
            ST_SYNC, ST_TRAIL: return h.a & h.b;
            ST_DATA:           return h.a ^ h.b;
            ST_PAUSE:          return ~h.a & ~h.b;
            default:           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mfd_tick.sv
module mfd_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)      cnt <= '0;
        else if (cnt == div) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == div);
endmodule

// File: rtl/mfd_frame.sv
module mfd_frame
    import mfd_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             line,
    output logic             accept,
    output logic [NBITS-1:0] byte_o
);
    localparam int PH_W  = $clog2(OSR);
    localparam int CNT_W = $clog2(NBITS);

    rx_state_e        state;
    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] cnt;
    halves_t          h;
    halves_t          h_now;
    logic [NBITS-1:0] shreg;
    logic             bit_end;
    logic             ok;

    // Second-half sample is taken at PH_B; at bit end both halves are known.
    assign h_now   = h;
    assign bit_end = tick && (ph == PH_W'(OSR - 1));
    assign ok      = halves_ok(state, h_now);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= ST_OFF;
            ph    <= '0;
            cnt   <= '0;
            h     <= '0;
            shreg <= '0;
        end else if (state == ST_OFF) begin
            state <= ST_START;
            ph    <= '0;
        end else if (tick) begin
            case (state)
                ST_START: begin
                    if (line)                         ph <= '0;
                    else if (ph == PH_W'(OSR - 1))  begin state <= ST_HUNT; ph <= '0; end
                    else                              ph <= ph + 1'b1;
                end
                ST_HUNT: begin
                    if (line) begin
                        state <= ST_SYNC;
                        ph    <= PH_W'(1);
                        cnt   <= '0;
                    end
                end
                default: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_W'(PH_A)) h.a <= line;
                    if (ph == PH_W'(PH_B)) h.b <= line;
                    if (ph == PH_W'(OSR - 1)) begin
                        ph <= '0;
                        if (!ok) begin
                            state <= ST_START;
                        end else begin
                            case (state)
                                ST_SYNC: begin
                                    if (cnt == CNT_W'(SYNC_BITS - 1)) begin
                                        state <= ST_DATA; cnt <= '0;
                                    end else cnt <= cnt + 1'b1;
                                end
                                ST_DATA: begin
                                    shreg <= {h.b, shreg[NBITS-1:1]};
                                    if (cnt == CNT_W'(NBITS - 1)) state <= ST_TRAIL;
                                    else cnt <= cnt + 1'b1;
                                end
                                ST_TRAIL: begin
                                    state <= ST_PAUSE; cnt <= '0;
                                end
                                default: begin
                                    if (cnt == CNT_W'(PAUSE_BITS - 1)) state <= ST_START;
                                    else cnt <= cnt + 1'b1;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign accept = en && bit_end && (state == ST_PAUSE) && ok &&
                    (cnt == CNT_W'(PAUSE_BITS - 1));
    assign byte_o = shreg;
endmodule

// File: rtl/mfd_hold.sv
module mfd_hold #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [NBITS-1:0] byte_i,
    input  logic             rd_stb,
    input  logic             ovr_clr,
    output logic [NBITS-1:0] data_out,
    output logic             full,
    output logic             overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            full     <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (accept && !full) begin
                data_out <= byte_i;
                full     <= 1'b1;
            end else if (rd_stb) begin
                full <= 1'b0;
            end
            if (accept && full) overrun <= 1'b1;
            else if (ovr_clr)   overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/mfd_rx.sv
module mfd_rx #(
    parameter int DIV_W = 8,
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             line_in,
    input  logic             rd_stb,
    input  logic             ovr_clr,
    output logic [NBITS-1:0] data_out,
    output logic             full,
    output logic             overrun,
    output logic             irq
);
    logic             s1, s2;
    logic             tick;
    logic             accept;
    logic [NBITS-1:0] rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= line_in;
            s2 <= s1;
        end
    end

    mfd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .en(en), .div(div), .tick(tick)
    );

    mfd_frame #(.NBITS(NBITS)) u_frame (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .line(s2),
        .accept(accept), .byte_o(rx_byte)
    );

    mfd_hold #(.NBITS(NBITS)) u_hold (
        .clk(clk), .rst(rst), .accept(accept), .byte_i(rx_byte),
        .rd_stb(rd_stb), .ovr_clr(ovr_clr),
        .data_out(data_out), .full(full), .overrun(overrun)
    );

    assign irq = full | overrun;
endmodule

// File: rtl/mfd_rx_chk.sv
module mfd_rx_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             rd_stb,
    input logic             ovr_clr,
    input logic [NBITS-1:0] data_out,
    input logic             full,
    input logic             overrun
);
    assert_disabled_no_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!en && !full) |=> !full);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(data_out));

    assert_ovr_needs_full_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(full));

    assert_rd_clears_full_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && full) |=> !full);

    assert_ovr_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (ovr_clr && !full) |=> !overrun);
endmodule

bind mfd_rx mfd_rx_chk #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst(rst), .en(en), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
    .data_out(data_out), .full(full), .overrun(overrun)
);

// File: tb/tb_mfd_rx.sv
`timescale 1ns/1ps
module tb_mfd_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] div = 8'd1;
    logic       line_in = 1'b0;
    logic       rd_stb = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] data_out;
    logic       full, overrun, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mfd_rx dut (
        .clk(clk), .rst(rst), .en(en), .div(div), .line_in(line_in),
        .rd_stb(rd_stb), .ovr_clr(ovr_clr), .data_out(data_out),
        .full(full), .overrun(overrun), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half(input logic lvl);
        line_in = lvl;
        repeat (8 * (int'(div) + 1)) @(negedge clk);
    endtask

    // pre: idle low halves; nsync: sync bits; bad: data bit without transition
    task automatic send(input logic [7:0] b, input int pre, input int nsync,
                        input int bad, input logic trl, input logic pz);
        for (int i = 0; i < pre; i++) half(1'b0);
        for (int i = 0; i < 2 * nsync; i++) half(1'b1);
        for (int i = 0; i < 8; i++) begin
            if (i == bad)   begin half(1'b1); half(1'b1); end
            else if (b[i])  begin half(1'b0); half(1'b1); end
            else            begin half(1'b1); half(1'b0); end
        end
        half(trl); half(trl);
        half(1'b0); half(1'b0);
        half(pz);   half(pz);
        for (int i = 0; i < 6; i++) half(1'b0);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_oc();
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data", data_out, 8'h00);
        chk("R1 full", full, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_disabled();
        en = 1'b0;
        send(8'h5A, 6, 2, -1, 1'b1, 1'b0);
        chk("R2 no load while disabled", full, 0);
        en = 1'b1; @(negedge clk);
    endtask

    task automatic t_good_c5();
        send(8'hC5, 6, 2, -1, 1'b1, 1'b0);
        chk("R6 lsb-first byte", data_out, 8'hC5);
        chk("R9 full set", full, 1);
        chk("R12 irq with full", irq, 1);
    endtask

    task automatic t_read();
        pulse_rd();
        chk("R11 read clears full", full, 0);
        chk("R12 irq low", irq, 0);
    endtask

    task automatic t_rate();
        div = 8'd3;
        send(8'h1E, 6, 2, -1, 1'b1, 1'b0);
        chk("R3 slower rate byte", data_out, 8'h1E);
        chk("R3 full", full, 1);
    endtask

    task automatic t_overrun();
        send(8'hF0, 6, 2, -1, 1'b1, 1'b0);
        chk("R10 overrun set", overrun, 1);
        chk("R10 data kept", data_out, 8'h1E);
        chk("R10 full kept", full, 1);
    endtask

    task automatic t_ovr_clear();
        pulse_oc();
        chk("R11 ovr_clr clears", overrun, 0);
        chk("R11 full untouched", full, 1);
        chk("R12 irq with full only", irq, 1);
        pulse_rd();
        div = 8'd1;
    endtask

    task automatic t_bad_end();
        send(8'h11, 6, 2, -1, 1'b0, 1'b0);
        chk("R8 bad trailer dropped", full, 0);
        send(8'h22, 6, 2, -1, 1'b1, 1'b1);
        chk("R8 bad pause dropped", full, 0);
    endtask

    task automatic t_no_trans();
        send(8'h33, 6, 2, 3, 1'b1, 1'b0);
        chk("R7 missing transition dropped", full, 0);
        send(8'h6B, 6, 2, -1, 1'b1, 1'b0);
        chk("R7 recovery byte", data_out, 8'h6B);
        pulse_rd();
    endtask

    task automatic t_bad_sync();
        send(8'h00, 6, 1, -1, 1'b1, 1'b0);
        chk("R5 short sync dropped", full, 0);
    endtask

    task automatic t_short_idle();
        line_in = 1'b1;
        repeat (3 * 16 * (int'(div) + 1)) @(negedge clk);
        send(8'h00, 1, 2, -1, 1'b1, 1'b0);
        chk("R4 unconfirmed idle dropped", full, 0);
        send(8'h81, 6, 2, -1, 1'b1, 1'b0);
        chk("R4 later frame received", data_out, 8'h81);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_good_c5();
        t_read();
        t_rate();
        t_overrun();
        t_ovr_clear();
        t_bad_end();
        t_no_trans();
        t_bad_sync();
        t_short_idle();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule